// File: doc/BRIEF.md
# Multi-Lane Variable-Size Bit-Reversal Reorderer

This block takes a block of samples that arrives on several parallel lanes, one group of lanes per clock, and sends it back out in bit-reversed index order. The reversal covers both the lane number and the timeslot number. The timeslot count per block is a power of two chosen at run time through a size code. The block therefore reverses an index whose width is the size code plus the lane-index width.

A full input block is written into one of two internal buffers at its natural positions. Once the block is complete, it is read back in permuted order while the next block of the same size fills the other buffer. Each buffer is split into one bank per lane. Elements are rotated across the banks on the way in, so that the lanes of any one output timeslot always hit different banks. A crossbar steers each bank's read data to its output lane.

The size may only change once every output at the old size has left the block.

Top module: `bitrev_lanes`

## Requirements
- R1: With LANES = 2^M (M at most 2), lane l occupies bits [l*DW +: DW] of `in_data` and of `out_data`. The input element taken on the t-th valid cycle of a block, on lane l, has index t*LANES + l. The size code `in_sz` may range from 2 to N-M.
- R2: Output timeslot q, lane k (position p = q*LANES + k) carries the input element whose index is the (sz+M)-bit bit-reversal of p.
- R3: With M = 2, sz = 3 and element values equal to their indices, the first output timeslot carries 0, 16, 8 and 24 on lanes 0 to 3.
- R4: The size code is taken on the first valid cycle of a block. The block ends after exactly 2^sz valid cycles, and idle cycles in between are allowed. The value of `in_sz` on idle cycles has no effect.
- R5: Each block produces exactly 2^sz output cycles with `out_vld` high and no gap between them. Blocks whose output is ready back to back leave the block as one unbroken run.
- R6: When no earlier block is pending, `out_vld` first rises two rising edges after the edge that captures the last input timeslot.
- R7: `out_sz` equals the block's size code on every valid output cycle and keeps that value after the output ends.
- R8: A following block of the same size may be presented while the previous block is being output, with no idle cycles. A new size is presented only after all output at the old size has been produced.
- R9: A block fed through twice comes back in its original order.
- R10: Reset drives `out_vld` low, clears `out_sz` and `out_data` to zero, and empties both buffers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input timeslot valid |
| in_data | input | 2^M*DW | Input lanes, lane l at [l*DW +: DW] |
| in_sz | input | clog2(N-M+1) | Timeslot count exponent of the current block |
| out_vld | output | 1 | Output timeslot valid |
| out_data | output | 2^M*DW | Output lanes, same packing as the input |
| out_sz | output | clog2(N-M+1) | Size code of the block being output |

## Verification
Output data and size become visible two edges after the first read of a block. That first read happens in the cycle after the edge that captures the block's last input timeslot, or directly after the previous block's output when one is still running. The bench never predicts absolute cycles for the reordered words. It compares every valid output timeslot, in order, against a queue of expected timeslots filled when the stimulus is issued. It samples on the falling edge, so every registered stage has settled. Timing is checked only where it is defined: the idle-start latency of exactly two edges, which is counted from the edge that takes the last input, and the length of unbroken `out_vld` runs.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;

    // Reverse the low w bits of p; bits at and above w are dropped.
    function automatic int unsigned rev_idx(input int unsigned p, input int unsigned w);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(w)) r[i] = p[w - 1 - i];
        end
        return r;
    endfunction

endpackage

// File: rtl/bitrev_bank.sv
module bitrev_bank #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/bitrev_xbar.sv
module bitrev_xbar #(
    parameter int L  = 4,
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic [L-1:0][DW-1:0] din,
    input  logic [L-1:0][SW-1:0] sel,
    output logic [L-1:0][DW-1:0] dout
);
    always_comb begin
        for (int k = 0; k < L; k++) dout[k] = din[sel[k]];
    end
endmodule

// File: rtl/bitrev_lanes.sv
module bitrev_lanes #(
    parameter int N  = 7,
    parameter int M  = 2,
    parameter int DW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic [(1<<M)*DW-1:0]       in_data,
    input  logic [$clog2(N-M+1)-1:0]   in_sz,
    output logic                       out_vld,
    output logic [(1<<M)*DW-1:0]       out_data,
    output logic [$clog2(N-M+1)-1:0]   out_sz
);
    localparam int L   = 1 << M;
    localparam int SZW = $clog2(N - M + 1);
    localparam int SLW = N - M;
    localparam int AW  = SLW + 1;
    localparam int SW  = (M > 0) ? M : 1;

    typedef struct packed {
        logic                  wbuf;
        logic [SLW-1:0]        wcnt;
        logic [SZW-1:0]        wsz;
        logic [1:0]            full;
        logic [1:0][SZW-1:0]   bsz;
        logic                  rbuf;
        logic [SLW-1:0]        rcnt;
        logic                  p1_vld;
        logic [SZW-1:0]        p1_sz;
        logic [L-1:0][SW-1:0]  p1_sel;
        logic                  out_vld;
        logic [SZW-1:0]        out_sz;
        logic [L-1:0][DW-1:0]  out_data;
    } state_t;

    state_t st_d, st_q;

    logic [L-1:0][DW-1:0] in_lanes, wr_lanes, bank_rd, rd_lanes;
    logic [L-1:0][SW-1:0] wr_sel, rd_sel;
    logic [L-1:0][AW-1:0] rd_addr;
    logic [L-1:0]         bank_hit;
    logic [SZW-1:0]       eff_sz, rd_sz;
    logic                 rd_go;
    int                   wr_rot;
    logic [SW-1:0]        map_bank;
    logic [SLW-1:0]       map_slot;

    assign in_lanes = in_data;

    // Bank and source slot that output lane k of output timeslot slot reads.
    function automatic logic [SW+SLW-1:0] rd_map(input logic [SLW-1:0] slot,
                                                 input int k,
                                                 input logic [SZW-1:0] sz);
        int unsigned p, s, lane, src, hi, bank;
        p    = (32'(slot) << M) | 32'(k);
        s    = bitrev_pkg::rev_idx(p, 32'(sz) + 32'(M));
        lane = s & (L - 1);
        src  = s >> M;
        hi   = src >> (int'(sz) - M);
        bank = (lane + hi) & (L - 1);
        return {SW'(bank), SLW'(src)};
    endfunction

    always_comb begin
        st_d = st_q;

        // write side: rotate lanes onto banks by the top M bits of the slot
        eff_sz = (st_q.wcnt == '0) ? in_sz : st_q.wsz;
        wr_rot = int'(st_q.wcnt) >> (int'(eff_sz) - M);
        for (int b = 0; b < L; b++) begin
            wr_sel[b] = SW'((b + L - (wr_rot & (L - 1))) & (L - 1));
        end
        if (in_vld) begin
            if (st_q.wcnt == '0) st_d.wsz = in_sz;
            if (int'(st_q.wcnt) == (1 << eff_sz) - 1) begin
                st_d.full[st_q.wbuf] = 1'b1;
                st_d.bsz[st_q.wbuf]  = eff_sz;
                st_d.wbuf            = ~st_q.wbuf;
                st_d.wcnt            = '0;
            end else begin
                st_d.wcnt = st_q.wcnt + 1'b1;
            end
        end

        // read side: a full buffer is read one output timeslot per cycle
        rd_sz    = st_q.bsz[st_q.rbuf];
        rd_go    = st_q.full[st_q.rbuf];
        rd_addr  = '0;
        bank_hit = '0;
        rd_sel   = '0;
        for (int k = 0; k < L; k++) begin
            {map_bank, map_slot} = rd_map(st_q.rcnt, k, rd_sz);
            rd_addr[map_bank]  = {st_q.rbuf, map_slot};
            bank_hit[map_bank] = 1'b1;
            rd_sel[k]          = map_bank;
        end
        st_d.p1_vld = rd_go;
        st_d.p1_sz  = rd_sz;
        st_d.p1_sel = rd_sel;
        if (rd_go) begin
            if (int'(st_q.rcnt) == (1 << rd_sz) - 1) begin
                st_d.full[st_q.rbuf] = 1'b0;
                st_d.rbuf            = ~st_q.rbuf;
                st_d.rcnt            = '0;
            end else begin
                st_d.rcnt = st_q.rcnt + 1'b1;
            end
        end

        // output stage
        st_d.out_vld = st_q.p1_vld;
        if (st_q.p1_vld) begin
            st_d.out_data = rd_lanes;
            st_d.out_sz   = st_q.p1_sz;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bitrev_xbar #(.L(L), .DW(DW), .SW(SW)) u_wr_xbar (
        .din(in_lanes), .sel(wr_sel), .dout(wr_lanes)
    );

    for (genvar g = 0; g < L; g++) begin : g_bank
        bitrev_bank #(.DW(DW), .AW(AW)) u_bank (
            .clk   (clk),
            .we    (in_vld),
            .waddr ({st_q.wbuf, st_q.wcnt}),
            .wdata (wr_lanes[g]),
            .re    (rd_go),
            .raddr (rd_addr[g]),
            .rdata (bank_rd[g])
        );
    end

    bitrev_xbar #(.L(L), .DW(DW), .SW(SW)) u_rd_xbar (
        .din(bank_rd), .sel(st_q.p1_sel), .dout(rd_lanes)
    );

    assign out_vld  = st_q.out_vld;
    assign out_data = st_q.out_data;
    assign out_sz   = st_q.out_sz;

    // checker state: position inside the current output block
    logic [SLW:0] chk_ocnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_ocnt_q <= '0;
        else if (out_vld) begin
            if (int'(chk_ocnt_q) == (1 << out_sz) - 1) chk_ocnt_q <= '0;
            else                                       chk_ocnt_q <= chk_ocnt_q + 1'b1;
        end
    end

    AST_SZ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && st_q.wcnt != '0) |-> (in_sz == st_q.wsz)); // R4
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> !st_q.full[st_q.wbuf]); // R8
    AST_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> ($countones(bank_hit) == L)); // R2
    AST_QSZ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(out_vld)) |-> $stable(out_sz)); // R7
    AST_RUN_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_vld) |-> (chk_ocnt_q == '0)); // R5
endmodule

// File: tb/tb_bitrev_lanes.sv
module tb_bitrev_lanes;
    localparam int N = 7, M = 2, DW = 8, L = 4, SZW = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_vld = 1'b0;
    logic [L*DW-1:0]     in_data = '0;
    logic [SZW-1:0]      in_sz = '0;
    logic                out_vld;
    logic [L*DW-1:0]     out_data;
    logic [SZW-1:0]      out_sz;

    bitrev_lanes #(.N(N), .M(M), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .in_sz(in_sz),
        .out_vld(out_vld), .out_data(out_data), .out_sz(out_sz)
    );

    always #4 clk = ~clk;

    int compared = 0, mismatched = 0, cyc = 0;
    int run = 0, last_run = 0, first_out_cyc = 0, last_in_edge = 0;
    bit prev_v = 0, done = 0;
    logic [L*DW-1:0] expq[$], gotq[$];
    logic [SZW-1:0]  eszq[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rev(input int p, input int w);
        int r = 0;
        for (int i = 0; i < w; i++) if (p & (1 << i)) r |= 1 << (w - 1 - i);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (out_vld) begin
            run++;
            gotq.push_back(out_data);
            if (!prev_v) first_out_cyc = cyc;
            if (expq.size() == 0) chk(0, "R5 extra output", out_data, 0);
            else begin
                logic [L*DW-1:0] e;
                logic [SZW-1:0] es;
                e  = expq.pop_front();
                es = eszq.pop_front();
                chk(out_data == e, "R2 data order", out_data, e);
                chk(out_sz == es, "R7 size tag", out_sz, es);
            end
        end else if (prev_v) begin
            last_run = run;
            run = 0;
        end
        prev_v = out_vld;
    end

    // natural=0: expect bit-reversed order; natural=1: expect blk unchanged (R9)
    task automatic push_exp(input logic [DW-1:0] blk[], input int sz, input bit natural);
        for (int q = 0; q < (1 << sz); q++) begin
            logic [L*DW-1:0] w;
            for (int k = 0; k < L; k++) begin
                int p = q * L + k;
                w[k*DW +: DW] = natural ? blk[p] : blk[rev(p, sz + M)];
            end
            expq.push_back(w);
            eszq.push_back(SZW'(sz));
        end
    endtask

    task automatic send_block(input logic [DW-1:0] blk[], input int sz, input int gap_pct);
        for (int t = 0; t < (1 << sz); t++) begin
            while ($urandom_range(99) < gap_pct) begin
                @(negedge clk);
                in_vld = 1'b0;
                in_sz  = SZW'($urandom);   // R4: ignored on idle cycles
            end
            @(negedge clk);
            in_vld = 1'b1;
            in_sz  = SZW'(sz);
            for (int l = 0; l < L; l++) in_data[l*DW +: DW] = blk[t*L + l];
            if (t == (1 << sz) - 1) last_in_edge = cyc + 1;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic flush();
        idle();
        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic rand_blk(output logic [DW-1:0] blk[], input int sz);
        blk = new[L << sz];
        foreach (blk[i]) blk[i] = DW'($urandom);
    endtask

    initial begin
        logic [DW-1:0] a[], b[], c[];
        int base, psz;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(out_vld == 1'b0, "R10 valid low", out_vld, 0);
        chk(out_sz == '0, "R10 size clear", out_sz, 0);
        chk(out_data == '0, "R10 data clear", out_data, 0);

        // R3 / R6 / R1: directed sz=3, values equal to indices, no gaps
        a = new[32];
        foreach (a[i]) a[i] = DW'(i);
        base = gotq.size();
        push_exp(a, 3, 0);
        send_block(a, 3, 0);
        flush();
        chk(gotq[base] == {8'd24, 8'd8, 8'd16, 8'd0}, "R3 first slot", gotq[base], {8'd24, 8'd8, 8'd16, 8'd0});
        chk(first_out_cyc - last_in_edge == 2, "R6 latency", first_out_cyc - last_in_edge, 2);
        chk(last_run == 8, "R5 run length sz3", last_run, 8);
        chk(out_sz == 3'd3, "R7 size held after output", out_sz, 3);

        // R4: sz=4 with idle gaps carrying junk sizes
        rand_blk(a, 4);
        push_exp(a, 4, 0);
        send_block(a, 4, 40);
        flush();
        chk(last_run == 16, "R4 block of 2^sz slots", last_run, 16);

        // R5 / R8: two minimum-size blocks back to back
        rand_blk(a, 2);
        rand_blk(b, 2);
        push_exp(a, 2, 0);
        push_exp(b, 2, 0);
        send_block(a, 2, 0);
        send_block(b, 2, 0);
        flush();
        chk(last_run == 8, "R5 unbroken run across blocks", last_run, 8);

        // R9: largest size through twice returns the original
        rand_blk(a, 5);
        push_exp(a, 5, 0);
        base = gotq.size();
        send_block(a, 5, 10);
        flush();
        c = new[L << 5];
        for (int q = 0; q < 32; q++)
            for (int l = 0; l < L; l++) c[q*L + l] = gotq[base + q][l*DW +: DW];
        push_exp(a, 5, 1);     // R9 expected: original order
        send_block(c, 5, 0);
        flush();

        // random mix of sizes; flush only on size change (R8)
        psz = 5;
        for (int n = 0; n < 30; n++) begin
            int sz = 2 + $urandom_range(3);
            if (sz != psz) flush();
            rand_blk(a, sz);
            push_exp(a, sz, 0);
            send_block(a, sz, 25);
            psz = sz;
        end
        flush();
        chk(expq.size() == 0, "R5 all output produced", expq.size(), 0);
        chk(out_vld == 1'b0, "R5 idle after flush", out_vld, 0);
        chk(out_sz == SZW'(psz), "R7 final size held", out_sz, psz);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule